// File: doc/BRIEF.md
# Nonvolatile Write Unlock Controller

This block sits between a CPU register bus and an on-chip nonvolatile memory array. It guards every program or erase cycle on that array. Software sets an enable bit, writes two fixed key bytes to a key port that has no storage behind it, and then sets a start bit. A cycle begins only when that order is kept exactly. The block then emits a one-cycle start strobe toward the array model. It holds the CPU stall line high for as long as a program-flash cycle is in progress. It drops the cycle when the array reports completion.

The block has two resets. The power-on reset clears everything. The system reset stands for an external pin or watchdog reset. If that reset arrives while a cycle is running, the block aborts the cycle and raises a write error flag. That flag survives the system reset and stays set until software writes zero to it.

The block also holds a table address pointer. Software loads it as three bytes. The top bit of the pointer marks a configuration-space access.

Top module: `nvm_unlock_ctrl`

## Requirements

Register map and bit layout:

- Register addresses: control at 0, key at 1, pointer low at 2, pointer high at 3, pointer upper at 4.
- Control register bits: 7 array select (1 = program flash, 0 = data EEPROM), 6 config space select, 5 reads as zero, 4 erase select, 3 write error, 2 write enable, 1 write start, 0 read start.

Requirements:

- R1: After power-on reset, the control register and all pointer bytes read 0, and nvm_start, nvm_read and cpu_stall are low.
- R2: Reads of the key register (address 1) return 0, and writes to it store nothing.
- R3: A cycle starts under all of the following conditions:
  - the control write sets bit 1 and bit 2;
  - write enable was already 1;
  - no cycle is running;
  - the two bus accesses just before it were key writes of 55h and then AAh.
  
  When it starts, nvm_start is high for exactly the one cycle after the write.
- R4: Any other bus access, or any wrong key value, between the key writes and the start write cancels the unlock. A second 55h in place of AAh also cancels it. A fresh 55h is then needed.
- R5: While write enable (bit 2) is 0, key writes and start writes have no effect.
- R6: Bit 1 reads 1 from the start of a cycle until the cycle after nvm_done is seen. Writing 0 to it does not clear it.
- R7: cpu_stall is high throughout a cycle whose array select (bit 7) is 1, and low for a data EEPROM cycle.
- R8: A system reset during a cycle, without nvm_done in that same cycle, aborts the cycle and sets bit 3. Bit 3 survives the system reset, writing 1 to it has no effect, writing 0 clears it, and power-on reset clears it.
- R9: Bits 7, 6 and 4 drive nvm_prog_sel, nvm_cfg_sel and nvm_erase. Writes to them are ignored while a cycle runs.
- R10: Pointer bytes form nvm_addr as {upper[5:0], high, low}. Upper bits 7:6 read 0. nvm_cfg_access equals pointer bit 21.
- R11: Writing 1 to bit 0 while idle gives a one-cycle nvm_read strobe. Bit 0 reads 1 only during that strobe cycle. The write is ignored while a cycle runs.
- R12: If nvm_done and a system reset fall in the same cycle, the cycle counts as completed and bit 3 stays 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst_n | input | 1 | Synchronous system (pin or watchdog) reset, active low |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| nvm_done | input | 1 | Array reports the running cycle complete |
| nvm_start | output | 1 | One-cycle program/erase start strobe |
| nvm_read | output | 1 | One-cycle read strobe |
| nvm_prog_sel | output | 1 | 1 = program flash, 0 = data EEPROM |
| nvm_cfg_sel | output | 1 | Access targets configuration space |
| nvm_erase | output | 1 | Cycle is an erase |
| nvm_addr | output | 22 | Table pointer |
| nvm_cfg_access | output | 1 | Pointer bit 21 |
| cpu_stall | output | 1 | Stall the CPU during a program-flash cycle |

## Verification

Two events can land on the same clock edge: the array's completion pulse and a system reset. The bench raises both in one cycle during a running program cycle. It expects the cycle to retire cleanly with the error bit still 0. It then repeats the reset alone and expects the error bit set. A software write to the control register can also land while the completion is pending. The bench sends select changes and a write-start clear during a busy cycle, and it judges both against a behavioural model that is compared on every clock.

// File: rtl/nvm_unlock_pkg.sv
package nvm_unlock_pkg;

   localparam int DATA_W = 8;

   // register addresses
   localparam int RA_CTRL = 0;
   localparam int RA_KEY  = 1;
   localparam int RA_PTR0 = 2;

   // control register bit positions (software decodes these)
   localparam int CB_RD    = 0;
   localparam int CB_WR    = 1;
   localparam int CB_WREN  = 2;
   localparam int CB_ERR   = 3;
   localparam int CB_ERASE = 4;
   localparam int CB_CFG   = 6;
   localparam int CB_ARRAY = 7;

   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_GOT1  = 2'd1,
      KS_ARMED = 2'd2
   } key_st_e;

   typedef struct packed {
      logic arr;
      logic cfg;
      logic ers;
      logic err;
      logic wren;
      logic wr;
      logic rd;
   } ctrl_fld_t;

endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
   import nvm_unlock_pkg::*;
#(
   parameter logic [DATA_W-1:0] KEY1 = 8'h55,
   parameter logic [DATA_W-1:0] KEY2 = 8'hAA
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              acc,
   input  logic              key_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wren,
   output logic              armed
);

   key_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (acc) begin
         if (key_wr && wren) begin
            unique case (st_q)
               KS_IDLE: st_d = (wdata == KEY1) ? KS_GOT1  : KS_IDLE;
               KS_GOT1: st_d = (wdata == KEY2) ? KS_ARMED : KS_IDLE;
               default: st_d = KS_IDLE;
            endcase
         end else begin
            st_d = KS_IDLE;
         end
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)          st_q <= KS_IDLE;
      else if (!sys_rst_n) st_q <= KS_IDLE;
      else                 st_q <= st_d;
   end

   assign armed = (st_q == KS_ARMED);

   // R4: the armed state is only entered from the first-key state
   a_r4_arm_after_first: assert property (@(posedge clk) disable iff (!por_n)
      (st_q == KS_ARMED && $past(st_q) != KS_ARMED) |-> $past(st_q == KS_GOT1));

endmodule

// File: rtl/nvm_ctrl_core.sv
module nvm_ctrl_core
   import nvm_unlock_pkg::*;
#(
   parameter bit STALL_ALL = 1'b0
) (
   input  logic      clk,
   input  logic      por_n,
   input  logic      sys_rst_n,
   input  logic      ctrl_wr,
   input  ctrl_fld_t wfld,
   input  logic      armed,
   input  logic      nvm_done,
   output ctrl_fld_t rfld,
   output logic      nvm_start,
   output logic      nvm_read,
   output logic      cpu_stall
);

   logic arr_q, cfg_q, ers_q, err_q, wren_q, wr_q, start_q, rd_q;
   logic start_ok, rd_ok;

   assign start_ok = ctrl_wr && armed && wfld.wr && wfld.wren && wren_q && !wr_q;
   assign rd_ok    = ctrl_wr && wfld.rd && !wr_q;

   // error flag: only power-on reset clears it by reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         err_q <= 1'b0;
      end else if (!sys_rst_n) begin
         if (wr_q && !nvm_done) err_q <= 1'b1;
      end else if (ctrl_wr && !wfld.err) begin
         err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         arr_q <= 1'b0; cfg_q <= 1'b0; ers_q <= 1'b0; wren_q <= 1'b0;
         wr_q <= 1'b0; start_q <= 1'b0; rd_q <= 1'b0;
      end else if (!sys_rst_n) begin
         arr_q <= 1'b0; cfg_q <= 1'b0; ers_q <= 1'b0; wren_q <= 1'b0;
         wr_q <= 1'b0; start_q <= 1'b0; rd_q <= 1'b0;
      end else begin
         start_q <= start_ok;
         rd_q    <= rd_ok;
         if (ctrl_wr) wren_q <= wfld.wren;
         if (ctrl_wr && !wr_q) begin
            arr_q <= wfld.arr;
            cfg_q <= wfld.cfg;
            ers_q <= wfld.ers;
         end
         if (start_ok)             wr_q <= 1'b1;
         else if (wr_q && nvm_done) wr_q <= 1'b0;
      end
   end

   generate
      if (STALL_ALL) begin : g_stall_all
         assign cpu_stall = wr_q;
      end else begin : g_stall_prog
         assign cpu_stall = wr_q && arr_q;
      end
   endgenerate

   assign nvm_start = start_q;
   assign nvm_read  = rd_q;
   assign rfld = '{arr: arr_q, cfg: cfg_q, ers: ers_q, err: err_q,
                   wren: wren_q, wr: wr_q, rd: rd_q};

   // R6: the write start bit only drops on completion or reset
   a_r6_wr_clear_cause: assert property (@(posedge clk) disable iff (!por_n)
      $fell(wr_q) |-> $past(nvm_done || !sys_rst_n));
   // R8: error only rises when a reset hits a running cycle
   a_r8_err_set_cause: assert property (@(posedge clk) disable iff (!por_n)
      $rose(err_q) |-> $past(!sys_rst_n && wr_q && !nvm_done));
   // R11: read strobe is a single cycle
   a_r11_read_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
      rd_q |=> !rd_q);
   // R3: start strobe is a single cycle
   a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
      start_q |=> !start_q);

endmodule

// File: rtl/nvm_tbl_ptr.sv
module nvm_tbl_ptr
   import nvm_unlock_pkg::*;
#(
   parameter int PTR_W  = 22,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [PTR_W-1:0]  ptr
);

   localparam int NB = (PTR_W + DATA_W - 1) / DATA_W;

   for (genvar gi = 0; gi < NB; gi++) begin : g_byte
      localparam int LO = gi * DATA_W;
      localparam int BW = (PTR_W - LO < DATA_W) ? (PTR_W - LO) : DATA_W;
      logic [BW-1:0] q;
      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n)                                          q <= '0;
         else if (!sys_rst_n)                                 q <= '0;
         else if (wr_en && addr == ADDR_W'(RA_PTR0 + gi))     q <= wdata[BW-1:0];
      end
      assign ptr[LO +: BW] = q;
   end

endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
   import nvm_unlock_pkg::*;
#(
   parameter int                PTR_W     = 22,
   parameter int                ADDR_W    = 3,
   parameter logic [DATA_W-1:0] KEY1      = 8'h55,
   parameter logic [DATA_W-1:0] KEY2      = 8'hAA,
   parameter bit                STALL_ALL = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              nvm_done,
   output logic              nvm_start,
   output logic              nvm_read,
   output logic              nvm_prog_sel,
   output logic              nvm_cfg_sel,
   output logic              nvm_erase,
   output logic [PTR_W-1:0]  nvm_addr,
   output logic              nvm_cfg_access,
   output logic              cpu_stall
);

   localparam int NB = (PTR_W + DATA_W - 1) / DATA_W;

   generate
      if (PTR_W < 2 * DATA_W + 1 || PTR_W > 3 * DATA_W) begin : g_bad_ptr
         $error("PTR_W must span exactly three bytes");
      end
      if ((2 ** ADDR_W) < RA_PTR0 + NB) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
      if (KEY1 == KEY2) begin : g_bad_key
         $error("the two unlock keys must differ");
      end
   endgenerate

   logic      ctrl_wr, key_wr, bus_wr, armed;
   ctrl_fld_t wfld, rfld;
   logic [PTR_W-1:0]     ptr;
   logic [NB*DATA_W-1:0] ptr_ext;

   assign bus_wr  = bus_sel && bus_we;
   assign ctrl_wr = bus_wr && bus_addr == ADDR_W'(RA_CTRL);
   assign key_wr  = bus_wr && bus_addr == ADDR_W'(RA_KEY);

   assign wfld = '{arr: bus_wdata[CB_ARRAY], cfg: bus_wdata[CB_CFG],
                   ers: bus_wdata[CB_ERASE], err: bus_wdata[CB_ERR],
                   wren: bus_wdata[CB_WREN], wr: bus_wdata[CB_WR],
                   rd: bus_wdata[CB_RD]};

   nvm_key_seq #(.KEY1(KEY1), .KEY2(KEY2)) u_key (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .acc(bus_sel),
      .key_wr(key_wr), .wdata(bus_wdata), .wren(rfld.wren), .armed(armed));

   nvm_ctrl_core #(.STALL_ALL(STALL_ALL)) u_core (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .ctrl_wr(ctrl_wr),
      .wfld(wfld), .armed(armed), .nvm_done(nvm_done), .rfld(rfld),
      .nvm_start(nvm_start), .nvm_read(nvm_read), .cpu_stall(cpu_stall));

   nvm_tbl_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wr_en(bus_wr),
      .addr(bus_addr), .wdata(bus_wdata), .ptr(ptr));

   assign ptr_ext = (NB*DATA_W)'(ptr);

   always_comb begin
      int off;
      off = int'(bus_addr) - RA_PTR0;
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(RA_CTRL)) begin
         bus_rdata[CB_ARRAY] = rfld.arr;
         bus_rdata[CB_CFG]   = rfld.cfg;
         bus_rdata[CB_ERASE] = rfld.ers;
         bus_rdata[CB_ERR]   = rfld.err;
         bus_rdata[CB_WREN]  = rfld.wren;
         bus_rdata[CB_WR]    = rfld.wr;
         bus_rdata[CB_RD]    = rfld.rd;
      end else if (off >= 0 && off < NB) begin
         bus_rdata = DATA_W'(ptr_ext >> (DATA_W * off));
      end
   end

   assign nvm_prog_sel   = rfld.arr;
   assign nvm_cfg_sel    = rfld.cfg;
   assign nvm_erase      = rfld.ers;
   assign nvm_addr       = ptr;
   assign nvm_cfg_access = ptr[PTR_W-1];

   // R3: a start strobe follows an armed unlock detector
   a_r3_start_after_arm: assert property (@(posedge clk) disable iff (!por_n)
      nvm_start |-> $past(armed));
   // R2: the key port always reads zero
   a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (!por_n)
      (bus_sel && !bus_we && bus_addr == ADDR_W'(RA_KEY)) |-> bus_rdata == '0);

endmodule

// File: tb/nvm_unlock_ctrl_bench.sv
module nvm_unlock_ctrl_bench;

   logic       clk = 1'b0;
   logic       por_n = 1'b0, sys_rst_n = 1'b1;
   logic       bus_sel = 1'b0, bus_we = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       nvm_done = 1'b0;
   logic       nvm_start, nvm_read, nvm_prog_sel, nvm_cfg_sel, nvm_erase;
   logic [21:0] nvm_addr;
   logic       nvm_cfg_access, cpu_stall;

   int n_chk = 0, n_fail = 0;
   bit cmp_en = 1'b0;

   always #2 clk = ~clk;

   nvm_unlock_ctrl u_nvm_unlock_ctrl (
      .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .nvm_done(nvm_done), .nvm_start(nvm_start),
      .nvm_read(nvm_read), .nvm_prog_sel(nvm_prog_sel), .nvm_cfg_sel(nvm_cfg_sel),
      .nvm_erase(nvm_erase), .nvm_addr(nvm_addr), .nvm_cfg_access(nvm_cfg_access),
      .cpu_stall(cpu_stall));

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
      end
   endtask

   // behavioural reference model
   int   mk;
   bit   m_arr, m_cfg, m_ers, m_err, m_wren, m_wr, m_start, m_rd;
   logic [21:0] m_ptr;

   always @(posedge clk) begin : model
      bit o_wr, o_wren; int o_k;
      o_wr = m_wr; o_wren = m_wren; o_k = mk;
      if (!por_n) begin
         mk = 0; m_arr = 0; m_cfg = 0; m_ers = 0; m_err = 0; m_wren = 0;
         m_wr = 0; m_start = 0; m_rd = 0; m_ptr = '0;
      end else if (!sys_rst_n) begin
         if (o_wr && !nvm_done) m_err = 1;
         mk = 0; m_arr = 0; m_cfg = 0; m_ers = 0; m_wren = 0;
         m_wr = 0; m_start = 0; m_rd = 0; m_ptr = '0;
      end else begin
         m_start = 0; m_rd = 0;
         if (o_wr && nvm_done) m_wr = 0;
         if (bus_sel) begin
            if (bus_we && bus_addr == 3'd1 && o_wren)
               mk = (o_k == 0 && bus_wdata == 8'h55) ? 1 :
                    (o_k == 1 && bus_wdata == 8'hAA) ? 2 : 0;
            else
               mk = 0;
            if (bus_we && bus_addr == 3'd0) begin
               m_wren = bus_wdata[2];
               if (!bus_wdata[3]) m_err = 0;
               if (!o_wr) begin
                  m_arr = bus_wdata[7]; m_cfg = bus_wdata[6]; m_ers = bus_wdata[4];
                  if (bus_wdata[0]) m_rd = 1;
               end
               if (o_k == 2 && bus_wdata[1] && bus_wdata[2] && o_wren && !o_wr) begin
                  m_wr = 1; m_start = 1;
               end
            end
            if (bus_we && bus_addr == 3'd2) m_ptr[7:0]   = bus_wdata;
            if (bus_we && bus_addr == 3'd3) m_ptr[15:8]  = bus_wdata;
            if (bus_we && bus_addr == 3'd4) m_ptr[21:16] = bus_wdata[5:0];
         end
      end
   end

   always @(negedge clk) begin
      if (cmp_en && por_n) begin
         chk("R3 start strobe", 32'(nvm_start), 32'(m_start));
         chk("R11 read strobe", 32'(nvm_read), 32'(m_rd));
         chk("R7 stall", 32'(cpu_stall), 32'(m_wr && m_arr));
         chk("R9 selects", 32'({nvm_prog_sel, nvm_cfg_sel, nvm_erase}),
             32'({m_arr, m_cfg, m_ers}));
         chk("R10 pointer", 32'(nvm_addr), 32'(m_ptr));
      end
   end

   task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_we = 0;
   endtask

   task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
      @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 chk(req, 32'(bus_rdata), 32'(exp));
      @(negedge clk); bus_sel = 0;
   endtask

   task automatic pulse_done();
      @(negedge clk); nvm_done = 1;
      @(negedge clk); nvm_done = 0;
   endtask

   task automatic pulse_sys(input bit with_done);
      @(negedge clk); sys_rst_n = 0; nvm_done = with_done;
      @(negedge clk); sys_rst_n = 1; nvm_done = 0;
   endtask

   task automatic pulse_por();
      cmp_en = 0;
      @(negedge clk); por_n = 0;
      @(negedge clk); por_n = 1;
      @(negedge clk); cmp_en = 1;
   endtask

   task automatic unlock_start(input logic [7:0] d);
      bus_wr(3'd1, 8'h55);
      bus_wr(3'd1, 8'hAA);
      bus_wr(3'd0, d);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1;
      @(negedge clk); cmp_en = 1;
      // R1 reset state
      bus_rd(3'd0, 8'h00, "R1 ctrl reset");
      bus_rd(3'd2, 8'h00, "R1 ptr low reset");
      bus_rd(3'd4, 8'h00, "R1 ptr upper reset");
      chk("R1 stall reset", 32'(cpu_stall), 0);
      // R2 key port
      bus_wr(3'd1, 8'h5A);
      bus_rd(3'd1, 8'h00, "R2 key reads zero");
      // R5 keys without write enable
      bus_wr(3'd0, 8'h80);
      unlock_start(8'h86);
      bus_rd(3'd0, 8'h84, "R5 no start without enable");
      // R3/R6/R7 good sequence, program flash
      bus_wr(3'd1, 8'h55);
      bus_wr(3'd1, 8'hAA);
      bus_wr(3'd0, 8'h86);
      chk("R3 start seen", 32'(nvm_start), 1);
      bus_rd(3'd0, 8'h86, "R6 wr set");
      chk("R7 stall program", 32'(cpu_stall), 1);
      bus_wr(3'd0, 8'h04);
      bus_rd(3'd0, 8'h86, "R6 R9 wr and select held");
      pulse_done();
      bus_rd(3'd0, 8'h84, "R6 wr cleared by done");
      chk("R7 stall released", 32'(cpu_stall), 0);
      // R4 broken sequences
      bus_wr(3'd1, 8'h55);
      bus_rd(3'd2, 8'h00, "R4 interleaved read");
      bus_wr(3'd1, 8'hAA);
      bus_wr(3'd0, 8'h86);
      bus_rd(3'd0, 8'h84, "R4 access between keys");
      bus_wr(3'd1, 8'h55);
      bus_wr(3'd1, 8'h55);
      bus_wr(3'd1, 8'hAA);
      bus_wr(3'd0, 8'h86);
      bus_rd(3'd0, 8'h84, "R4 repeated first key");
      bus_wr(3'd1, 8'h55);
      bus_wr(3'd1, 8'hA5);
      bus_wr(3'd0, 8'h86);
      bus_rd(3'd0, 8'h84, "R4 wrong second key");
      // R7 data EEPROM erase: no stall
      bus_wr(3'd0, 8'h04);
      unlock_start(8'h16);
      bus_rd(3'd0, 8'h16, "R9 erase eeprom cycle");
      chk("R7 no stall for eeprom", 32'(cpu_stall), 0);
      pulse_done();
      // R8 reset aborts a running cycle
      bus_wr(3'd0, 8'h84);
      unlock_start(8'h86);
      pulse_sys(1'b0);
      bus_rd(3'd0, 8'h08, "R8 error after abort");
      bus_wr(3'd0, 8'h0C);
      bus_rd(3'd0, 8'h0C, "R8 write one keeps error");
      bus_wr(3'd0, 8'h04);
      bus_rd(3'd0, 8'h04, "R8 write zero clears error");
      // R12 reset and done in the same cycle
      bus_wr(3'd0, 8'h84);
      unlock_start(8'h86);
      pulse_sys(1'b1);
      bus_rd(3'd0, 8'h00, "R12 done beats reset");
      // R10 pointer
      bus_wr(3'd2, 8'h34);
      bus_wr(3'd3, 8'h12);
      bus_wr(3'd4, 8'hFF);
      bus_rd(3'd4, 8'h3F, "R10 upper byte width");
      bus_rd(3'd3, 8'h12, "R10 high byte");
      chk("R10 address out", 32'(nvm_addr), 32'h3F1234);
      chk("R10 config access", 32'(nvm_cfg_access), 1);
      // R11 read strobe
      bus_wr(3'd0, 8'h01);
      chk("R11 read strobe seen", 32'(nvm_read), 1);
      bus_rd(3'd0, 8'h00, "R11 rd bit clear");
      bus_wr(3'd0, 8'h84);
      unlock_start(8'h87);
      bus_wr(3'd0, 8'h85);
      chk("R11 read ignored while busy", 32'(nvm_read), 0);
      pulse_done();
      // R8 power-on reset clears the error
      bus_wr(3'd0, 8'h84);
      unlock_start(8'h86);
      pulse_sys(1'b0);
      bus_rd(3'd0, 8'h08, "R8 error set again");
      pulse_por();
      bus_rd(3'd0, 8'h00, "R8 R1 por clears error");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule